// File: doc/BRIEF.md
# Byte-Wide Multiplexed-Address DRAM Controller

This block sits between a simple CPU-side request/ready handshake and a bank of eight one-bit dynamic memory devices. The eight devices share one 8-bit address bus, one active-low row strobe, one active-low column strobe and one write enable. Each device holds one bit of every byte, so together they form a 64K x 8 memory. A 16-bit CPU address is split into a row half (bits 15:8) and a column half (bits 7:0). The two halves are sent one after the other on the shared pins: first the row, latched by the row strobe, and then the column, latched by the column strobe.

The dynamic cells need refreshing, so the controller runs its own interval timer and an 8-bit row counter. It refreshes rows by pulsing only the row strobe, with the row counter value on the pins. After every such cycle the counter moves to the next row, so all 256 rows are visited in turn. Refresh and CPU accesses compete for the one bus. A pending refresh is started only while the controller is idle, and it never cuts into an access. A CPU request that arrives while a refresh is running simply waits, with ready held low. After reset the controller runs eight refresh cycles before it serves any CPU request.

The CPU holds `cpu_req` together with its address, direction and write data until it sees a one-clock `cpu_ready` pulse. For a read, `cpu_rdata` is valid in that same clock.

Top module: `bytewide_dram_ctrl`

## Requirements
- R1: During and straight after reset, both strobes and the write enable are high, the data lines are not driven and `cpu_ready` is low.
- R2: After reset, exactly eight row-strobe-only refresh cycles complete before the column strobe falls for the first time, even if a CPU request is already waiting.
- R3: In an access, the row half (address bits 15:8) is on the address pins for one clock before the row strobe falls and stays there. The column half (bits 7:0) replaces it ROW_CLKS clocks after the row strobe falls. The column strobe falls one clock later, while the row strobe is still low.
- R4: In a write, the write enable goes low and the write byte is driven on the data outputs (output-enable high) one clock before the column strobe falls. Both stay in place until the column strobe rises.
- R5: In a read, the data input is sampled CAS_CLKS clocks after the column strobe falls. `cpu_rdata` then shows the byte last written to that address.
- R6: A refresh cycle lowers the row strobe for RAS_CLKS clocks. During that time the column strobe and the write enable stay high.
- R7: The refresh row on the pins goes up by one after each refresh cycle and wraps from 255 to 0.
- R8: When no CPU traffic is present, refresh cycles start exactly REF_INTERVAL clocks apart.
- R9: A refresh never interrupts an access. A request raised during a refresh gets no `cpu_ready` until that refresh and its precharge have finished, and it is served after them.
- R10: At the end of every cycle both strobes return high. They stay high for at least PRE_CLKS clocks before the row strobe falls again.
- R11: `cpu_ready` is high for exactly one clock per served request. That clock is the first clock after the column strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Byte address (row = 15:8, column = 7:0) |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | One-clock completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_ready` |
| mem_a | output | 8 | Shared multiplexed address pins |
| mem_row_stb_n | output | 1 | Active-low row strobe |
| mem_col_stb_n | output | 1 | Active-low column strobe |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data to the devices, one bit per device |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | 8 | Data from the devices |

## Verification
Directed accesses at the corner addresses 0x0000 and 0xFFFF, and at addresses whose row and column halves differ (0x12 row with 0x34 column, and the reverse), show whether the two halves reach the pins in the right order and without a swap. A long stream of writes, each followed by a read-back, with LFSR-generated addresses and data and with an older address read again in between, keeps CPU traffic colliding with the refresh timer. This separates correct arbitration from a refresh that cuts into an access or one that gets lost. An idle stretch shows the bare refresh interval. A request raised just after a refresh has begun shows the stall, and the run is long enough for the row counter to wrap.

// File: rtl/mdram_pkg.sv
package mdram_pkg;

   // Sequencer states: access path, refresh path, shared precharge
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ASET,
      SQ_AROW,
      SQ_ACOL,
      SQ_ACAS,
      SQ_RSET,
      SQ_RHOLD,
      SQ_PRE
   } sq_state_t;

   // Source placed on the shared address pins
   typedef enum logic [1:0] {
      AM_ROW,
      AM_COL,
      AM_RFR
   } amux_sel_t;

endpackage

// File: rtl/mdram_addr_mux.sv
module mdram_addr_mux
   import mdram_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int MUX_W    = 8,
   parameter bit ROW_HIGH = 1'b1
) (
   input  amux_sel_t          sel,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [MUX_W-1:0]   rfr_row,
   output logic [MUX_W-1:0]   mux_a
);

   logic [MUX_W-1:0] row_part;
   logic [MUX_W-1:0] col_part;

   generate
      if (ADDR_W != 2 * MUX_W) begin : g_bad_split
         $error("mdram_addr_mux: ADDR_W must be twice MUX_W");
      end

      if (ROW_HIGH) begin : g_row_upper
         assign row_part = acc_addr[ADDR_W-1 -: MUX_W];
         assign col_part = acc_addr[MUX_W-1:0];
      end else begin : g_row_lower
         assign row_part = acc_addr[MUX_W-1:0];
         assign col_part = acc_addr[ADDR_W-1 -: MUX_W];
      end
   endgenerate

   always_comb begin
      case (sel)
         AM_COL:  mux_a = col_part;
         AM_RFR:  mux_a = rfr_row;
         default: mux_a = row_part;
      endcase
   end

endmodule

// File: rtl/mdram_refresh.sv
module mdram_refresh #(
   parameter int INTERVAL = 120,
   parameter int ROW_W    = 8,
   parameter int INIT_CNT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rfr_start,
   input  logic             rfr_done,
   output logic             rfr_need,
   output logic [ROW_W-1:0] rfr_row,
   output logic             init_done
);

   localparam int TW = $clog2(INTERVAL);
   localparam int IW = $clog2(INIT_CNT + 1);

   generate
      if (INTERVAL < 2) begin : g_bad_interval
         $error("mdram_refresh: INTERVAL must be at least 2");
      end
      if (INIT_CNT < 1) begin : g_bad_init
         $error("mdram_refresh: INIT_CNT must be at least 1");
      end
   endgenerate

   logic [TW-1:0] tmr;
   logic          due_q;
   logic [IW-1:0] init_cnt;
   logic          tick;

   assign tick      = (tmr == TW'(INTERVAL - 1));
   assign init_done = (init_cnt == IW'(INIT_CNT));
   assign rfr_need  = due_q || !init_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr      <= '0;
         due_q    <= 1'b0;
         init_cnt <= '0;
         rfr_row  <= '0;
      end else begin
         tmr <= tick ? '0 : tmr + 1'b1;
         if (tick)
            due_q <= 1'b1;
         else if (rfr_start)
            due_q <= 1'b0;
         if (rfr_done) begin
            rfr_row <= rfr_row + 1'b1;
            if (!init_done)
               init_cnt <= init_cnt + 1'b1;
         end
      end
   end

   // R7: each completed refresh moves to the next row, wrapping at the top
   a_r7_row_advance: assert property (@(posedge clk) disable iff (!rst_n)
      rfr_done |=> rfr_row == $past(rfr_row) + 1'b1);

endmodule

// File: rtl/mdram_seq.sv
module mdram_seq
   import mdram_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int ROW_CLKS = 2,
   parameter int CAS_CLKS = 2,
   parameter int RAS_CLKS = 3,
   parameter int PRE_CLKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rfr_need,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [DATA_W-1:0] dq_in,
   output logic              row_stb_n,
   output logic              col_stb_n,
   output logic              we_n,
   output logic              dq_oe,
   output logic [DATA_W-1:0] dq_out,
   output amux_sel_t         sel,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              ready,
   output logic [DATA_W-1:0] rdata,
   output logic              rfr_start,
   output logic              rfr_done
);

   localparam int MAX_AB = (ROW_CLKS > CAS_CLKS) ? ROW_CLKS : CAS_CLKS;
   localparam int MAX_CD = (RAS_CLKS > PRE_CLKS) ? RAS_CLKS : PRE_CLKS;
   localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int CW     = $clog2(MAXC + 1);
   localparam int HW     = $clog2(PRE_CLKS + 1) + 1;

   generate
      if (ROW_CLKS < 1 || CAS_CLKS < 1 || RAS_CLKS < 1 || PRE_CLKS < 1) begin : g_bad_timing
         $error("mdram_seq: every timing parameter must be at least 1");
      end
   endgenerate

   sq_state_t         state;
   logic [CW-1:0]     cnt;
   logic              acc_we;
   logic [DATA_W-1:0] acc_wdata;
   logic              rdy_q;
   logic              last;

   assign last = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         cnt       <= '0;
         acc_we    <= 1'b0;
         acc_addr  <= '0;
         acc_wdata <= '0;
         rdata     <= '0;
         rdy_q     <= 1'b0;
      end else begin
         rdy_q <= 1'b0;
         case (state)
            SQ_IDLE: begin
               if (rfr_need) begin
                  state <= SQ_RSET;
               end else if (cpu_req) begin
                  state     <= SQ_ASET;
                  acc_we    <= cpu_we;
                  acc_addr  <= cpu_addr;
                  acc_wdata <= cpu_wdata;
               end
            end
            SQ_ASET: begin
               state <= SQ_AROW;
               cnt   <= CW'(ROW_CLKS - 1);
            end
            SQ_AROW: begin
               if (last) state <= SQ_ACOL;
               else      cnt   <= cnt - 1'b1;
            end
            SQ_ACOL: begin
               state <= SQ_ACAS;
               cnt   <= CW'(CAS_CLKS - 1);
            end
            SQ_ACAS: begin
               if (last) begin
                  state <= SQ_PRE;
                  cnt   <= CW'(PRE_CLKS - 1);
                  rdy_q <= 1'b1;
                  if (!acc_we) rdata <= dq_in;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            SQ_RSET: begin
               state <= SQ_RHOLD;
               cnt   <= CW'(RAS_CLKS - 1);
            end
            SQ_RHOLD: begin
               if (last) begin
                  state <= SQ_PRE;
                  cnt   <= CW'(PRE_CLKS - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            SQ_PRE: begin
               if (last) state <= SQ_IDLE;
               else      cnt   <= cnt - 1'b1;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      row_stb_n = !(state inside {SQ_AROW, SQ_ACOL, SQ_ACAS, SQ_RHOLD});
      col_stb_n = (state != SQ_ACAS);
      dq_oe     = acc_we && (state inside {SQ_ACOL, SQ_ACAS});
      we_n      = !dq_oe;
      dq_out    = acc_wdata;
      ready     = rdy_q;
      rfr_start = (state == SQ_IDLE) && rfr_need;
      rfr_done  = (state == SQ_RHOLD) && last;
      if (state inside {SQ_RSET, SQ_RHOLD})
         sel = AM_RFR;
      else if (state inside {SQ_ACOL, SQ_ACAS})
         sel = AM_COL;
      else
         sel = AM_ROW;
   end

   // Run length of the row strobe being high, saturating at PRE_CLKS
   logic [HW-1:0] hi_run;
   always_ff @(posedge clk) begin
      if (!rst_n)
         hi_run <= HW'(PRE_CLKS);
      else if (!row_stb_n)
         hi_run <= '0;
      else if (hi_run < HW'(PRE_CLKS))
         hi_run <= hi_run + 1'b1;
   end

   // R10: the row strobe only falls after a full precharge
   a_r10_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(row_stb_n) |-> hi_run >= HW'(PRE_CLKS));

   // R3: the column strobe falls only inside an open row
   a_r3_col_in_row: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(col_stb_n) |-> !row_stb_n && $past(!row_stb_n));

   // R4: write enable and data are set up before the column strobe falls
   a_r4_write_setup: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(col_stb_n) && !we_n) |-> $past(!we_n) && $past(dq_oe));

   // R11: ready is a single-clock pulse
   a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);

endmodule

// File: rtl/bytewide_dram_ctrl.sv
module bytewide_dram_ctrl
   import mdram_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 8,
   parameter bit ROW_HIGH     = 1'b1,
   parameter int ROW_CLKS     = 2,
   parameter int CAS_CLKS     = 2,
   parameter int RAS_CLKS     = 3,
   parameter int PRE_CLKS     = 2,
   parameter int REF_INTERVAL = 120,
   parameter int INIT_REFRESH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_wdata,
   output logic              cpu_ready,
   output logic [7:0]        cpu_rdata,
   output logic [7:0]        mem_a,
   output logic              mem_row_stb_n,
   output logic              mem_col_stb_n,
   output logic              mem_we_n,
   output logic [7:0]        mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [7:0]        mem_dq_in
);

   localparam int MUX_W = ADDR_W / 2;

   generate
      if (ADDR_W != 16 || DATA_W != 8) begin : g_bad_port_w
         $error("bytewide_dram_ctrl: ports are sized for a 16-bit address and 8-bit data");
      end
   endgenerate

   amux_sel_t         sel;
   logic [ADDR_W-1:0] acc_addr;
   logic [MUX_W-1:0]  rfr_row;
   logic              rfr_need;
   logic              rfr_start;
   logic              rfr_done;
   logic              init_done;

   mdram_refresh #(
      .INTERVAL (REF_INTERVAL),
      .ROW_W    (MUX_W),
      .INIT_CNT (INIT_REFRESH)
   ) u_refresh (
      .clk       (clk),
      .rst_n     (rst_n),
      .rfr_start (rfr_start),
      .rfr_done  (rfr_done),
      .rfr_need  (rfr_need),
      .rfr_row   (rfr_row),
      .init_done (init_done)
   );

   mdram_seq #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .ROW_CLKS (ROW_CLKS),
      .CAS_CLKS (CAS_CLKS),
      .RAS_CLKS (RAS_CLKS),
      .PRE_CLKS (PRE_CLKS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .rfr_need  (rfr_need),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .dq_in     (mem_dq_in),
      .row_stb_n (mem_row_stb_n),
      .col_stb_n (mem_col_stb_n),
      .we_n      (mem_we_n),
      .dq_oe     (mem_dq_oe),
      .dq_out    (mem_dq_out),
      .sel       (sel),
      .acc_addr  (acc_addr),
      .ready     (cpu_ready),
      .rdata     (cpu_rdata),
      .rfr_start (rfr_start),
      .rfr_done  (rfr_done)
   );

   mdram_addr_mux #(
      .ADDR_W   (ADDR_W),
      .MUX_W    (MUX_W),
      .ROW_HIGH (ROW_HIGH)
   ) u_mux (
      .sel      (sel),
      .acc_addr (acc_addr),
      .rfr_row  (rfr_row),
      .mux_a    (mem_a)
   );

   // R2: no column strobe before the start-up refresh burst is complete
   a_r2_init_burst: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> mem_col_stb_n);

   // R3: the address pins hold still across every row strobe fall
   a_r3_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_row_stb_n) |-> $stable(mem_a));

endmodule

// File: tb/bytewide_dram_ctrl_test.sv
module bytewide_dram_ctrl_test;

   localparam int ROW_CLKS = 2;
   localparam int CAS_CLKS = 2;
   localparam int RAS_CLKS = 3;
   localparam int PRE_CLKS = 2;
   localparam int INTERVAL = 40;
   localparam int BASE_LAT = 3 + ROW_CLKS + CAS_CLKS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_req = 1'b0;
   logic       cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0] cpu_wdata = '0;
   logic       cpu_ready;
   logic [7:0] cpu_rdata;
   logic [7:0] mem_a;
   logic       mem_row_stb_n;
   logic       mem_col_stb_n;
   logic       mem_we_n;
   logic [7:0] mem_dq_out;
   logic       mem_dq_oe;
   logic [7:0] mem_dq_in = 8'hA5;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   bytewide_dram_ctrl #(
      .ROW_CLKS     (ROW_CLKS),
      .CAS_CLKS     (CAS_CLKS),
      .RAS_CLKS     (RAS_CLKS),
      .PRE_CLKS     (PRE_CLKS),
      .REF_INTERVAL (INTERVAL),
      .INIT_REFRESH (8)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req       (cpu_req),
      .cpu_we        (cpu_we),
      .cpu_addr      (cpu_addr),
      .cpu_wdata     (cpu_wdata),
      .cpu_ready     (cpu_ready),
      .cpu_rdata     (cpu_rdata),
      .mem_a         (mem_a),
      .mem_row_stb_n (mem_row_stb_n),
      .mem_col_stb_n (mem_col_stb_n),
      .mem_we_n      (mem_we_n),
      .mem_dq_out    (mem_dq_out),
      .mem_dq_oe     (mem_dq_oe),
      .mem_dq_in     (mem_dq_in)
   );

   task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // ---------------- cycle reference model ----------------
   typedef struct {
      logic       r;
      logic       c;
      logic       w;
      logic       oe;
      logic       rdy;
      logic       chk_ma;
      logic [7:0] ma;
      logic [7:0] dq;
      int         rq;
   } exp_t;

   function automatic exp_t mk(logic r, logic c, logic w, logic oe, logic rdy,
                               logic chk_ma, logic [7:0] ma, logic [7:0] dq, int rq);
      exp_t e;
      e.r = r; e.c = c; e.w = w; e.oe = oe; e.rdy = rdy;
      e.chk_ma = chk_ma; e.ma = ma; e.dq = dq; e.rq = rq;
      return e;
   endfunction

   exp_t       q[$];
   exp_t       cur;
   int         tcnt;
   bit         pend;
   int         nref;
   logic [7:0] mrow;
   bit         took;
   bit         tk;

   // R10 tail of every cycle: precharge (ready on its first clock for accesses), then idle
   task automatic push_tail(input logic rdy);
      q.push_back(mk(1, 1, 1, 0, rdy, 0, 8'h00, 8'h00, 11));
      repeat (PRE_CLKS - 1) q.push_back(mk(1, 1, 1, 0, 0, 0, 8'h00, 8'h00, 10));
      q.push_back(mk(1, 1, 1, 0, 0, 0, 8'h00, 8'h00, 10));
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         tcnt = 0; pend = 0; nref = 0; mrow = 8'h00;
         cur = mk(1, 1, 1, 0, 0, 0, 8'h00, 8'h00, 1);
      end else begin
         took = 0;
         if (q.size() == 0) begin
            if (nref < 8 || pend) begin
               // R6/R7: row-only refresh of the next row
               took = 1;
               if (nref < 8) nref++;
               q.push_back(mk(1, 1, 1, 0, 0, 1, mrow, 8'h00, 7));
               repeat (RAS_CLKS) q.push_back(mk(0, 1, 1, 0, 0, 1, mrow, 8'h00, 6));
               push_tail(1'b0);
               mrow = mrow + 8'd1;
            end else if (cpu_req) begin
               // R3/R4: row setup, row hold, column setup, column strobe
               q.push_back(mk(1, 1, 1, 0, 0, 1, cpu_addr[15:8], 8'h00, 3));
               repeat (ROW_CLKS) q.push_back(mk(0, 1, 1, 0, 0, 1, cpu_addr[15:8], 8'h00, 3));
               q.push_back(mk(0, 1, !cpu_we, cpu_we, 0, 1, cpu_addr[7:0], cpu_wdata, 3));
               repeat (CAS_CLKS) q.push_back(mk(0, 0, !cpu_we, cpu_we, 0, 1, cpu_addr[7:0], cpu_wdata, 3));
               push_tail(1'b1);
            end
         end
         // R8: timer fires every INTERVAL clocks
         tk = (tcnt == INTERVAL - 1);
         tcnt = tk ? 0 : tcnt + 1;
         if (tk) pend = 1;
         else if (took) pend = 0;
         if (q.size() != 0) cur = q.pop_front();
         else cur = mk(1, 1, 1, 0, 0, 0, 8'h00, 8'h00, 10);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(cur.rq, "row strobe", mem_row_stb_n, cur.r);
         chk(cur.rq, "column strobe", mem_col_stb_n, cur.c);
         chk(4, "write enable", mem_we_n, cur.w);
         chk(4, "data drive", mem_dq_oe, cur.oe);
         if (cur.oe) chk(4, "write data", mem_dq_out, cur.dq);
         if (cur.chk_ma) chk(cur.rq, "address pins", mem_a, cur.ma);
         chk(11, "ready", cpu_ready, cur.rdy);
      end
   end

   // ---------------- memory devices and pin monitor ----------------
   logic [7:0] dram [int];
   logic [7:0] shadow [int];
   logic       ras_prev = 1'b1;
   logic       cas_prev = 1'b1;
   logic [7:0] lat_row = 8'h00;
   bit         cas_seen = 0;
   bit         first_cas = 1;
   int         nref_mon = 0;
   int         last_row = 0;
   int         wraps = 0;
   int         cyc = 0;
   int         start_cyc = 0;
   int         prev_start = 0;
   bit         have_prev = 0;
   bit         idle_win = 0;
   int         key;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         ras_prev = 1'b1; cas_prev = 1'b1;
      end else begin
         if (ras_prev && !mem_row_stb_n) begin
            lat_row = mem_a; cas_seen = 0; start_cyc = cyc;
         end
         if (cas_prev && !mem_col_stb_n) begin
            cas_seen = 1;
            if (first_cas) begin
               first_cas = 0;
               chk(2, "refreshes before first access", nref_mon, 8);
            end
            if (!mem_we_n) dram[{lat_row, mem_a}] = mem_dq_out;
         end
         if (!ras_prev && mem_row_stb_n && !cas_seen) begin
            if (nref_mon > 0) begin
               chk(7, "refresh row step", lat_row, (last_row + 1) % 256);
               if (lat_row == 8'h00) wraps++;
            end
            last_row = lat_row;
            nref_mon++;
            if (idle_win) begin
               if (have_prev) chk(8, "refresh spacing", start_cyc - prev_start, INTERVAL);
               have_prev = 1;
               prev_start = start_cyc;
            end else begin
               have_prev = 0;
            end
         end
         key = {lat_row, mem_a};
         if (!mem_col_stb_n && mem_we_n)
            mem_dq_in = dram.exists(key) ? dram[key] : 8'h00;
         else
            mem_dq_in = 8'hA5;
         ras_prev = mem_row_stb_n;
         cas_prev = mem_col_stb_n;
      end
   end

   // ---------------- CPU side ----------------
   task automatic cpu_op(input bit w, input logic [15:0] a, input logic [7:0] d, output int lat);
      int k;
      k = a;
      @(negedge clk);
      cpu_req = 1; cpu_we = w; cpu_addr = a; cpu_wdata = d;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!cpu_ready);
      if (!w)
         chk(5, "read data", cpu_rdata, shadow.exists(k) ? shadow[k] : 8'h00);  // R5
      else
         shadow[k] = d;
      cpu_req = 0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin : main
      int lat;
      logic [15:0] lfsr;
      logic [15:0] hist [$];
      lfsr = 16'hACE1;
      // R1: idle pins while reset is held
      repeat (3) @(negedge clk);
      chk(1, "row strobe in reset", mem_row_stb_n, 1'b1);
      chk(1, "column strobe in reset", mem_col_stb_n, 1'b1);
      chk(1, "write enable in reset", mem_we_n, 1'b1);
      chk(1, "data drive in reset", mem_dq_oe, 1'b0);
      chk(1, "ready in reset", cpu_ready, 1'b0);
      rst_n = 1'b1;
      // R2: request waiting from the first clock; start-up burst goes first
      cpu_op(1, 16'h1234, 8'h5A, lat);
      // R3: corner and swapped-half addresses
      cpu_op(1, 16'h0000, 8'h01, lat);
      cpu_op(1, 16'hFFFF, 8'h80, lat);
      cpu_op(1, 16'h3412, 8'hC3, lat);
      cpu_op(0, 16'h1234, 8'h00, lat);
      cpu_op(0, 16'h3412, 8'h00, lat);
      cpu_op(0, 16'hFFFF, 8'h00, lat);
      cpu_op(0, 16'h0000, 8'h00, lat);
      // R9: long mixed stream keeps colliding with the refresh timer
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         hist.push_back(lfsr);
         cpu_op(1, lfsr, lfsr[7:0] ^ lfsr[15:8] ^ 8'(i), lat);
         cpu_op(0, lfsr, 8'h00, lat);
         if (i % 3 == 0) cpu_op(0, hist[i / 2], 8'h00, lat);
      end
      // R8: idle stretch, refresh alone
      repeat (60) @(negedge clk);
      idle_win = 1;
      repeat (8 * INTERVAL) @(negedge clk);
      idle_win = 0;
      // R9: request raised just after a refresh has started
      while (mem_row_stb_n) @(negedge clk);
      cpu_op(0, 16'h1234, 8'h00, lat);
      chk(9, "stall behind refresh", lat > BASE_LAT, 1'b1);
      // R7: counter wrapped at least once over the run
      chk(7, "row counter wrapped", wraps > 0, 1'b1);
      repeat (5) @(negedge clk);
      summary();
   end

endmodule